// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic read and write an external 8192 x 8 static RAM that has no clock. The RAM is selected only when one active-low enable is low and one active-high enable is high. It also has an active-low output enable and an active-low write enable, and its data pins are shared between reading and writing. On the user side the controller takes a single-cycle request with a direction flag, an address and write data. It reports `busy_o` while a cycle runs. When a cycle finishes it pulses `done_o`, and after a read it presents the read data.

All analog timing minimums are given in nanoseconds as parameters. Each one is rounded up to a whole number of clock cycles using the clock-period parameter. The controller drives the shared bus only while the RAM write enable is low, which is also when the RAM has its outputs turned off. It inserts a bus turnaround gap between a read and a following write.

A level-sensitive retention input parks the RAM with both enables inactive. When the input drops, the enables stay inactive for one read-cycle time before the controller goes back to idle.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `ram_ce1_no`, `ram_oe_no` and `ram_we_no` are 1, and `busy_o` and `done_o` are 0.
- R2: A read holds the read strobes for L_RD = ceil(max(T_RC, T_AA, T_OA) / CLK_NS) cycles. The read strobes are `ram_ce1_no`=0, `ram_ce2_o`=1, `ram_oe_no`=0 and `ram_we_no`=1. The bus is sampled at the clock edge that ends the strobe window. `done_o` is high for exactly one cycle and appears L_RD+1 falling edges after the accepting edge, with `rdata_o` valid at that time.
- R3: A write holds `ram_ce1_no`=0, `ram_ce2_o`=1 and `ram_we_no`=0 for L_WP = ceil(max(T_WP, T_DS) / CLK_NS) cycles. During that window `ram_oe_no` stays 1, and the address and the driven data stay constant.
- R4: A write cycle, counted from acceptance to completion, lasts max(L_WP, ceil(T_RC / CLK_NS)) cycles. `done_o` appears one falling edge after the cycle ends.
- R5: The controller drives `ram_dq_io` only while `ram_we_no` is 0.
- R6: A write that follows a read is delayed by L_TA = max(1, ceil(T_OD / CLK_NS)) cycles. During these cycles `ram_oe_no` and `ram_we_no` are both 1, before `ram_we_no` falls. This adds L_TA to the write completion latency.
- R7: `busy_o` is 1 from the accepting edge until the completing edge. A request presented while busy is dropped and does not change the memory.
- R8: While `ret_req_i` is 1 in retention, `ram_ce1_no`=1, `ram_ce2_o`=0 and `busy_o`=1. Requests are dropped.
- R9: After `ret_req_i` falls, the enables stay inactive and `busy_o` stays 1 for L_RC = ceil(T_RC / CLK_NS) cycles. After that the controller is idle.
- R10: If `ret_req_i` and `req_i` are both high in the same idle cycle, the controller enters retention and the request is lost.
- R11: Data written to any address is returned unchanged by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Word address |
| wdata_i | input | 8 | Write data |
| ret_req_i | input | 1 | Retention request, level |
| rdata_o | output | 8 | Last read data |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Cycle or retention in progress |
| ram_addr_o | output | 13 | RAM address |
| ram_ce1_no | output | 1 | RAM enable, active low |
| ram_ce2_o | output | 1 | RAM enable, active high |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_dq_io | inout | 8 | Shared RAM data bus |

## Verification
The RAM model in the bench holds the wrong value (the inverted word) on the bus until the access count has elapsed. A controller that samples even one edge early therefore returns corrupted data. The model also measures the width of every write pulse, how long the data was stable before the pulse ended, and whether OE stayed high, so a shortened pulse or a wobbling OE shows up as a failure. It also measures the gap between OE rising and WE falling, which a design without turnaround would break on read-to-write sequences. Requests issued mid-read, during retention and together with a retention request are followed by read-back of the target address, so any leaked write appears as changed data. The exact recovery length after retention is counted from the busy output.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_RD, ST_WR, ST_WREC, ST_RET, ST_RECOV
  } seq_st_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - {{(CW-1){1'b0}}, 1'b1};
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CW     = 4,
  parameter int unsigned L_RD   = 11,
  parameter int unsigned L_WP   = 8,
  parameter int unsigned L_WREC = 3,
  parameter int unsigned L_TA   = 4,
  parameter int unsigned L_RC   = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic wr_i,
  input  logic ret_i,
  input  logic zero_i,
  output logic load_o,
  output logic [CW-1:0] load_val_o,
  output logic accept_o,
  output logic sample_o,
  output logic done_o,
  output logic busy_o,
  output logic ce1_n_o,
  output logic ce2_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic drv_o
);
  localparam bit            HAS_WREC = (L_WREC > 0);
  localparam logic [CW-1:0] LD_RD   = CW'(L_RD - 1);
  localparam logic [CW-1:0] LD_WP   = CW'(L_WP - 1);
  localparam logic [CW-1:0] LD_TA   = CW'(L_TA - 1);
  localparam logic [CW-1:0] LD_RC   = CW'(L_RC - 1);
  localparam logic [CW-1:0] LD_WREC = HAS_WREC ? CW'(L_WREC - 1) : '0;

  seq_st_e st_q, st_d;
  logic fin, rd_last_q;
  logic ce1_n_q, ce2_q, oe_n_q, we_n_q, drv_q, done_q;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    sample_o   = 1'b0;
    fin        = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ret_i) st_d = ST_RET;
        else if (req_i) begin
          accept_o = 1'b1;
          load_o   = 1'b1;
          if (!wr_i) begin
            st_d = ST_RD;   load_val_o = LD_RD;
          end else if (rd_last_q) begin
            st_d = ST_TURN; load_val_o = LD_TA;
          end else begin
            st_d = ST_WR;   load_val_o = LD_WP;
          end
        end
      end
      ST_TURN: if (zero_i) begin
        st_d = ST_WR; load_o = 1'b1; load_val_o = LD_WP;
      end
      ST_RD: if (zero_i) begin
        st_d = ST_IDLE; sample_o = 1'b1; fin = 1'b1;
      end
      ST_WR: if (zero_i) begin
        if (HAS_WREC) begin
          st_d = ST_WREC; load_o = 1'b1; load_val_o = LD_WREC;
        end else begin
          st_d = ST_IDLE; fin = 1'b1;
        end
      end
      ST_WREC: if (zero_i) begin
        st_d = ST_IDLE; fin = 1'b1;
      end
      ST_RET: if (!ret_i) begin
        st_d = ST_RECOV; load_o = 1'b1; load_val_o = LD_RC;
      end
      ST_RECOV: if (zero_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state so they toggle on a clean edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ce1_n_q   <= 1'b1;
      ce2_q     <= 1'b1;
      oe_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      drv_q     <= 1'b0;
      done_q    <= 1'b0;
      rd_last_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ce1_n_q <= !(st_d == ST_RD || st_d == ST_WR);
      ce2_q   <= !(st_d == ST_RET || st_d == ST_RECOV);
      oe_n_q  <= (st_d != ST_RD);
      we_n_q  <= (st_d != ST_WR);
      drv_q   <= (st_d == ST_WR);
      done_q  <= fin;
      if (sample_o)              rd_last_q <= 1'b1;
      else if (accept_o && wr_i) rd_last_q <= 1'b0;
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign ce1_n_o = ce1_n_q;
  assign ce2_o   = ce2_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign drv_o   = drv_q;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_read_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> (!ce1_n_q && ce2_q && we_n_q));
  assert_oe_static_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> oe_n_q);
  assert_ret_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RET || st_q == ST_RECOV) |-> (ce1_n_q && !ce2_q));
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned AW       = 13,
  parameter int unsigned DW       = 8,
  parameter int unsigned CLK_NS   = 5,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_OA_NS  = 30,
  parameter int unsigned T_WP_NS  = 40,
  parameter int unsigned T_DS_NS  = 25,
  parameter int unsigned T_OD_NS  = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ret_req_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          busy_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_ce1_no,
  output logic          ram_ce2_o,
  output logic          ram_oe_no,
  output logic          ram_we_no,
  inout  wire  [DW-1:0] ram_dq_io
);
  localparam int unsigned N_RC   = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned L_RD   = umax(1, umax(N_RC, umax(ns2cyc(T_AA_NS, CLK_NS),
                                                          ns2cyc(T_OA_NS, CLK_NS))));
  localparam int unsigned L_WP   = umax(1, umax(ns2cyc(T_WP_NS, CLK_NS),
                                                ns2cyc(T_DS_NS, CLK_NS)));
  localparam int unsigned L_WREC = (N_RC > L_WP) ? N_RC - L_WP : 0;
  localparam int unsigned L_TA   = umax(1, ns2cyc(T_OD_NS, CLK_NS));
  localparam int unsigned L_RC   = umax(1, N_RC);
  localparam int unsigned L_MAX  = umax(umax(L_RD, L_WP), umax(umax(L_WREC, L_TA), L_RC));
  localparam int unsigned CW     = $clog2(L_MAX + 1);

  logic          load, zero, accept, sample, drv_en;
  logic [CW-1:0] load_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  sram_ctl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sram_ctl_seq #(
    .CW(CW), .L_RD(L_RD), .L_WP(L_WP), .L_WREC(L_WREC), .L_TA(L_TA), .L_RC(L_RC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .ret_i      (ret_req_i),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .sample_o   (sample),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .ce1_n_o    (ram_ce1_no),
    .ce2_o      (ram_ce2_o),
    .oe_n_o     (ram_oe_no),
    .we_n_o     (ram_we_no),
    .drv_o      (drv_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (sample) rdata_q <= ram_dq_io;
    end
  end

  assign ram_addr_o = addr_q;
  assign rdata_o    = rdata_q;
  assign ram_dq_io  = drv_en ? wdata_q : {DW{1'bz}};

  assert_drv_we_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en |-> !ram_we_no);
  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_we_no && $past(!ram_we_no)) |-> $stable(ram_addr_o));
  assert_rd_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_oe_no && $past(!ram_oe_no)) |-> $stable(ram_addr_o));
endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;
  localparam int CLK = 5;
  localparam int B_CYC = (55 + CLK - 1) / CLK;
  localparam int B_AA  = (55 + CLK - 1) / CLK;
  localparam int B_OA  = (30 + CLK - 1) / CLK;
  localparam int B_WP  = (40 + CLK - 1) / CLK;
  localparam int B_DS  = (25 + CLK - 1) / CLK;
  localparam int B_OD  = (20 + CLK - 1) / CLK;
  localparam int B_RD  = (B_CYC > B_AA) ? ((B_CYC > B_OA) ? B_CYC : B_OA)
                                        : ((B_AA > B_OA) ? B_AA : B_OA);
  localparam int B_PW  = (B_WP > B_DS) ? B_WP : B_DS;
  localparam int B_WR  = (B_PW > B_CYC) ? B_PW : B_CYC;
  localparam int B_TA  = (B_OD > 1) ? B_OD : 1;
  localparam int B_RC  = B_CYC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, ret = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, ram_q;
  logic done, busy, ce1_n, ce2, oe_n, we_n;
  logic [12:0] ram_a;
  wire  [7:0]  dq;

  int total = 0, bad = 0;
  bit last_rd = 0;

  always #2.5 clk = ~clk;

  sram_ctl u_sram_ctl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ret_req_i(ret), .rdata_o(rdata), .done_o(done),
    .busy_o(busy), .ram_addr_o(ram_a), .ram_ce1_no(ce1_n), .ram_ce2_o(ce2),
    .ram_oe_no(oe_n), .ram_we_no(we_n), .ram_dq_io(dq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // RAM model: wrong data until access time has elapsed
  logic [7:0] mem     [0:8191];
  logic [7:0] exp_mem [0:8191];
  int rcnt = 0, wp = 0, ds = 0, gap = 0;
  bit seen_rd = 0, oe_bad = 0;
  logic [7:0]  wd_l = '0;
  logic [12:0] wa_l = '0;
  logic rd_act, wr_act;

  assign rd_act = !ce1_n && ce2 && !oe_n && we_n;
  assign wr_act = !ce1_n && ce2 && !we_n;
  assign ram_q  = (rcnt >= B_AA && rcnt >= B_OA) ? mem[ram_a] : ~mem[ram_a];
  assign dq     = rd_act ? ram_q : 8'bz;

  always @(negedge clk) begin
    if (rst_n) begin
      rcnt <= rd_act ? rcnt + 1 : 0;
      if (wr_act) begin
        wp   <= wp + 1;
        ds   <= (wp != 0 && dq == wd_l) ? ds + 1 : 1;
        wd_l <= dq;
        wa_l <= ram_a;
        if (!oe_n) oe_bad <= 1'b1;
      end else if (wp != 0) begin
        chk(wp >= B_WP, "R3 pulse width", wp, B_WP);
        chk(ds >= B_DS, "R3 data setup", ds, B_DS);
        chk(!oe_bad, "R3 oe static", int'(oe_bad), 0);
        mem[wa_l] <= wd_l;
        wp <= 0;
        oe_bad <= 1'b0;
      end
      if (!oe_n) begin
        gap <= 0; seen_rd <= 1'b1;
      end else if (wr_act && wp == 0 && seen_rd) begin
        chk(gap >= B_TA, "R6 turnaround", gap, B_TA);
        seen_rd <= 1'b0;
      end else if (we_n) gap <= gap + 1;
    end
  end

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 37 + (a >> 5) + s * 91) & 255);
  endfunction

  task automatic op(input bit w, input int a, input logic [7:0] d, input string tag);
    int n, lat;
    lat = w ? (B_WR + 1 + (last_rd ? B_TA : 0)) : (B_RD + 1);
    @(negedge clk);
    req = 1'b1; wr = w; addr = 13'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; n = 1;
    chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(n == lat, tag, n, lat);
    if (w) exp_mem[a] = d;
    else chk(rdata == exp_mem[a], "R11 readback", rdata, exp_mem[a]);
    last_rd = !w;
  endtask

  task automatic wait_idle(input int exp_n, input string tag);
    int n;
    n = 0;
    while (busy && n < 200) begin
      chk(ce1_n && !ce2, "R9 enables off", {ce1_n, ce2}, 2);
      @(negedge clk); n++;
    end
    chk(n == exp_n, tag, n, exp_n);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(ce1_n && oe_n && we_n && !busy && !done, "R1 in reset", {ce1_n, oe_n, we_n, busy, done}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce1_n && oe_n && we_n && !busy && !done, "R1 after reset", {ce1_n, oe_n, we_n, busy, done}, 5'b11100);

    // sweep both ends of the address space
    for (int a = 0; a < 256; a++) op(1'b1, a, pat(a, 0), "R4 write latency");
    for (int a = 7936; a < 8192; a++) op(1'b1, a, pat(a, 0), "R4 write latency");
    for (int a = 0; a < 256; a++) op(1'b0, a, 8'h00, "R2 read latency");
    for (int a = 7936; a < 8192; a++) op(1'b0, a, 8'h00, "R2 read latency");
    // interleaved read -> write -> read for turnaround
    for (int a = 0; a < 64; a++) begin
      op(1'b0, a * 128, 8'h00, "R2 read latency");
      op(1'b1, a * 128, pat(a, 1), "R6 write after read latency");
      op(1'b0, a * 128, 8'h00, "R2 read latency");
    end
    for (int a = 1; a < 8192; a = a * 2) begin
      op(1'b1, a, 8'(a ^ 8'hA5), "R4 write latency");
      op(1'b0, a, 8'h00, "R11 walking address");
    end

    // R7: request while a read is running is dropped
    op(1'b1, 100, 8'h3C, "R4 write latency");
    @(negedge clk); req = 1'b1; wr = 1'b0; addr = 13'd5;
    @(negedge clk); req = 1'b0;
    repeat (2) @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 13'd100; wdata = 8'hEE;
    @(negedge clk); req = 1'b0;
    while (!done) @(negedge clk);
    chk(rdata == exp_mem[5], "R7 read during busy", rdata, exp_mem[5]);
    last_rd = 1;
    @(negedge clk);
    chk(!busy, "R7 no extra cycle", int'(busy), 0);
    op(1'b0, 100, 8'h00, "R7 dropped write");

    // R8/R9: retention
    @(negedge clk); ret = 1'b1;
    @(negedge clk);
    chk(ce1_n && !ce2 && busy, "R8 retention state", {ce1_n, ce2, busy}, 3'b101);
    req = 1'b1; wr = 1'b1; addr = 13'd100; wdata = 8'h11;
    repeat (3) @(negedge clk);
    req = 1'b0;
    chk(ce1_n && !ce2 && busy, "R8 retention held", {ce1_n, ce2, busy}, 3'b101);
    ret = 1'b0;
    @(negedge clk);
    wait_idle(B_RC, "R9 recovery length");
    op(1'b0, 100, 8'h00, "R8 no write in retention");

    // R10: retention wins over a same-cycle request
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 13'd101; wdata = 8'h22; ret = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(!ce2 && ce1_n, "R10 retention taken", {ce1_n, ce2}, 2);
    @(negedge clk); ret = 1'b0;
    @(negedge clk);
    wait_idle(B_RC, "R9 recovery length");
    op(1'b0, 101, 8'h00, "R10 request lost");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * CLK);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule